// File: doc/BRIEF.md
# Chip-Select-Framed Serial Word Receiver with Echo Output

This block is the receive front end of a three-wire write bus. A host lowers chip select, clocks sixteen bits in most significant bit first, then raises chip select. The block captures one bit on each rising serial-clock edge while chip select is low. When chip select rises after exactly sixteen bits, it hands the word to a downstream command decoder with a single system-clock strobe. A frame of any other length raises a one-cycle framing-error flag instead, and the previous word is kept.

The bit that leaves the top of the shift register drives an echo output, so that devices can be chained by wiring one echo output to the next data input. The echo launch edge is an input driven by the command decoder. With rising-edge launch the echo trails the data input by 16 serial clocks. With falling-edge launch it trails by 16.5 serial clocks. The serial pins are asynchronous to the system clock. They pass through two-flop synchronizers, and edges are found in the system clock, which must run at least four times faster than the serial clock.

Top module: `serial_word_rx`

## Requirements
- R1: The frame is 16 bits long and sent MSB first. The first bit captured lands in word_o[15], so the two address bits sit in [15:14], the two control bits in [13:12] and the data in [11:0].
- R2: Bits are captured only on rising serial-clock edges while cs_ni is low. Serial-clock edges while cs_ni is high leave the shift register and the echo state unchanged.
- R3: When cs_ni rises after exactly 16 captured bits, word_o takes the received word and word_vld_o is high for exactly one system clock.
- R4: When cs_ni rises after any bit count other than 16, frame_err_o is high for one system clock, word_vld_o stays low and word_o keeps its previous value.
- R5: With echo_mode_i = 1, dout_o changes only on rising serial-clock edges and shows the bit captured 16 rising edges earlier.
- R6: With echo_mode_i = 0, dout_o changes only on falling serial-clock edges. It shows the bit captured at the rising edge 16.5 serial clocks earlier.
- R7: After reset, dout_o, word_o, word_vld_o and frame_err_o are all 0, and the shift register and bit count are zero.
- R8: While clr_ni is low, dout_o is 0 at once, with no clock needed. From the next system-clock edge the shift register, bit count, echo state and word_o are zero.
- R9: A frame may be sent as two 8-bit bursts with an idle gap between them, as long as cs_ni stays low, and it is received the same as a continuous frame.
- R10: Each serial pin passes two synchronizer flops and one edge-detect flop. word_vld_o is therefore high after the third system-clock edge that follows the cs_ni rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_ni | input | 1 | Clear, active low; empties the registers and forces the echo output low |
| sclk_i | input | 1 | Serial clock pin |
| cs_ni | input | 1 | Chip select pin, active low |
| din_i | input | 1 | Serial data pin |
| echo_mode_i | input | 1 | Echo launch edge: 0 = falling, 1 = rising |
| dout_o | output | 1 | Echo output for chaining |
| word_o | output | 16 | Last complete 16-bit word |
| word_vld_o | output | 1 | One-cycle strobe when word_o is updated |
| frame_err_o | output | 1 | One-cycle strobe when a frame has the wrong length |

## Verification
A wrong bit count shows within three system clocks of the chip-select rise: a missing strobe, a spurious framing error, or a word shifted by one bit. Corrupted shift-register contents appear on the echo output one serial clock per bit. A wrong launch edge or an extra echo stage moves the echo by half a serial period. The reference model compares the echo output on every system clock, so that shift is caught at the first edge where the two disagree.

// File: rtl/ws_pkg.sv
package ws_pkg;
  typedef enum logic {
    ECHO_FALL = 1'b0,
    ECHO_RISE = 1'b1
  } echo_mode_e;

  localparam int unsigned PIN_DIN  = 0;
  localparam int unsigned PIN_SCLK = 1;
  localparam int unsigned PIN_CS   = 2;
  localparam int unsigned PIN_NUM  = 3;
endpackage

// File: rtl/ws_pin_sync.sv
module ws_pin_sync #(
  parameter int unsigned         W       = 3,
  parameter int unsigned         STAGES  = 2,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[i] <= RST_VAL;
        else         stg[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[i] <= RST_VAL;
        else         stg[i] <= stg[i-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= stg[STAGES-1];
  end

  assign q_o    = stg[STAGES-1];
  assign rise_o = stg[STAGES-1] & ~prev_q;
  assign fall_o = ~stg[STAGES-1] & prev_q;
endmodule

// File: rtl/ws_frame_ctrl.sv
module ws_frame_ctrl #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              sclk_rise_i,
  input  logic              cs_low_i,
  input  logic              cs_rise_i,
  input  logic              din_i,
  output logic              msb_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              frame_err_o
);
  localparam int unsigned CNT_W   = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q        <= '0;
      cnt_q       <= '0;
      word_o      <= '0;
      word_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
    end else if (!clr_ni) begin
      sr_q        <= '0;
      cnt_q       <= '0;
      word_o      <= '0;
      word_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      word_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
      if (sclk_rise_i && cs_low_i) begin
        sr_q <= {sr_q[WORD_W-2:0], din_i};
        // saturate so an overlong frame never wraps back to a legal count
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      if (cs_rise_i) begin
        cnt_q <= '0;
        if (cnt_q == CNT_FULL) begin
          word_o     <= sr_q;
          word_vld_o <= 1'b1;
        end else begin
          frame_err_o <= 1'b1;
        end
      end
    end
  end

  assign msb_o = sr_q[WORD_W-1];

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R1
  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o); // R3
  AST_VLD_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_vld_o && frame_err_o)); // R4
  AST_WORD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_ni) && !word_vld_o) |-> $stable(word_o)); // R4
endmodule

// File: rtl/ws_echo.sv
module ws_echo (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  input  logic mode_i,
  input  logic sclk_rise_i,
  input  logic sclk_fall_i,
  input  logic cs_low_i,
  input  logic msb_i,
  output logic dout_o
);
  import ws_pkg::*;

  logic rise_q;
  logic fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (!clr_ni) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      if (sclk_rise_i && cs_low_i) rise_q <= msb_i;
      // half-cycle retime of the rising-edge copy gives the extra 0.5 clock
      if (sclk_fall_i && cs_low_i) fall_q <= rise_q;
    end
  end

  assign dout_o = clr_ni & ((echo_mode_e'(mode_i) == ECHO_RISE) ? rise_q : fall_q);

  AST_FALL_HOLDS_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise_i |=> $stable(fall_q)); // R6
  AST_RISE_HOLDS_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_fall_i |=> $stable(rise_q)); // R5
  AST_CLR_ECHO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> (rise_q == 1'b0 && fall_q == 1'b0)); // R8
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              din_i,
  input  logic              echo_mode_i,
  output logic              dout_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              frame_err_o
);
  import ws_pkg::*;

  localparam logic [PIN_NUM-1:0] PIN_RST = PIN_NUM'(1 << PIN_CS);

  logic [PIN_NUM-1:0] pin_raw, pin_q, pin_rise, pin_fall;
  logic               msb;

  assign pin_raw[PIN_DIN]  = din_i;
  assign pin_raw[PIN_SCLK] = sclk_i;
  assign pin_raw[PIN_CS]   = cs_ni;

  ws_pin_sync #(
    .W       (PIN_NUM),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_RST)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_raw),
    .q_o    (pin_q),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  ws_frame_ctrl #(.WORD_W(WORD_W)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_ni      (clr_ni),
    .sclk_rise_i (pin_rise[PIN_SCLK]),
    .cs_low_i    (~pin_q[PIN_CS]),
    .cs_rise_i   (pin_rise[PIN_CS]),
    .din_i       (pin_q[PIN_DIN]),
    .msb_o       (msb),
    .word_o      (word_o),
    .word_vld_o  (word_vld_o),
    .frame_err_o (frame_err_o)
  );

  ws_echo u_echo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_ni      (clr_ni),
    .mode_i      (echo_mode_i),
    .sclk_rise_i (pin_rise[PIN_SCLK]),
    .sclk_fall_i (pin_fall[PIN_SCLK]),
    .cs_low_i    (~pin_q[PIN_CS]),
    .msb_i       (msb),
    .dout_o      (dout_o)
  );
endmodule

// File: tb/sim_serial_word_rx.sv
`timescale 1ns/1ps
module sim_serial_word_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0, clr_n = 1'b1, sclk = 1'b0, cs_n = 1'b1, din = 1'b0, mode = 1'b0;
  logic dout, vld, err;
  logic [15:0] word;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  serial_word_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .sclk_i(sclk), .cs_ni(cs_n),
    .din_i(din), .echo_mode_i(mode), .dout_o(dout), .word_o(word),
    .word_vld_o(vld), .frame_err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %0h exp %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference: pin history, shift value, counters
  bit h_sc[4], h_cs[4], h_di[4];
  int m_sr, m_cnt, m_word;
  bit m_rise, m_fall, m_vld, m_err;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin h_sc[i] = 0; h_cs[i] = 1; h_di[i] = 0; end
      m_sr = 0; m_cnt = 0; m_word = 0; m_rise = 0; m_fall = 0; m_vld = 0; m_err = 0;
    end else begin
      for (int i = 3; i > 0; i--) begin h_sc[i] = h_sc[i-1]; h_cs[i] = h_cs[i-1]; h_di[i] = h_di[i-1]; end
      h_sc[0] = sclk; h_cs[0] = cs_n; h_di[0] = din;
      if (!clr_n) begin
        m_sr = 0; m_cnt = 0; m_word = 0; m_rise = 0; m_fall = 0; m_vld = 0; m_err = 0;
      end else begin
        m_vld = 0; m_err = 0;
        if (h_sc[2] && !h_sc[3] && !h_cs[2]) begin
          m_rise = m_sr[15];
          m_sr = ((m_sr << 1) | h_di[2]) & 16'hFFFF;
          m_cnt++;
        end else if (!h_sc[2] && h_sc[3] && !h_cs[2]) begin
          m_fall = m_rise;
        end
        if (h_cs[2] && !h_cs[3]) begin
          if (m_cnt == 16) begin m_word = m_sr; m_vld = 1; end
          else m_err = 1;
          m_cnt = 0;
        end
      end
      #5;
      begin
        bit exp_do;
        exp_do = clr_n & (mode ? m_rise : m_fall);
        chk(dout === exp_do, mode ? "R5 dout" : "R6 dout", int'(dout), int'(exp_do));
        chk(word === m_word[15:0], "R3 word", int'(word), m_word);
        chk(vld === m_vld, "R3 vld", int'(vld), int'(m_vld));
        chk(err === m_err, "R4 err", int'(err), int'(m_err));
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk); din = b;
    wait_clk(4); sclk = 1'b1;
    wait_clk(4); sclk = 1'b0;
  endtask

  task automatic frame(input logic [15:0] w, input int nbits);
    @(negedge clk); cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) send_bit(w[15 - (i % 16)]);
    wait_clk(4); cs_n = 1'b1;
    wait_clk(8);
  endtask

  initial begin
    wait_clk(2);
    #5;
    chk(dout === 0 && word === 0 && vld === 0 && err === 0, "R7 reset", int'(word), 0);
    wait_clk(3); rst_n = 1'b1;
    wait_clk(3);

    mode = 1'b1;
    frame(16'hA5C3, 16);
    chk(word === 16'hA5C3, "R1 msb first", int'(word), 16'hA5C3);

    // clock while deselected must not disturb the shifter
    din = 1'b1;
    for (int i = 0; i < 3; i++) begin wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0; end
    frame(16'h0F0F, 16);
    chk(word === 16'h0F0F, "R2 ignore deselected", int'(word), 16'h0F0F);

    mode = 1'b0;
    frame(16'h1234, 16);
    frame(16'h8001, 16);
    chk(word === 16'h8001, "R6 frame", int'(word), 16'h8001);

    frame(16'hFFFF, 12);
    chk(word === 16'h8001, "R4 short keeps word", int'(word), 16'h8001);

    // two bursts with a gap
    @(negedge clk); cs_n = 1'b0; wait_clk(4);
    for (int i = 0; i < 8; i++) send_bit(1'(16'h6C39 >> (15 - i)));
    wait_clk(30);
    for (int i = 8; i < 16; i++) send_bit(1'(16'h6C39 >> (15 - i)));
    wait_clk(4); cs_n = 1'b1; wait_clk(8);
    chk(word === 16'h6C39, "R9 split frame", int'(word), 16'h6C39);

    // strobe timing after chip-select rise
    mode = 1'b1;
    @(negedge clk); cs_n = 1'b0; wait_clk(4);
    for (int i = 0; i < 16; i++) send_bit(1'(16'h3C5A >> (15 - i)));
    wait_clk(4); cs_n = 1'b1;
    @(posedge clk); #5 chk(vld === 0, "R10 edge1", int'(vld), 0);
    @(posedge clk); #5 chk(vld === 0, "R10 edge2", int'(vld), 0);
    @(posedge clk); #5 chk(vld === 1, "R10 edge3", int'(vld), 1);
    wait_clk(6);

    // clear mid-frame
    @(negedge clk); cs_n = 1'b0; wait_clk(4);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    @(negedge clk); clr_n = 1'b0;
    #1 chk(dout === 0, "R8 dout forced", int'(dout), 0);
    wait_clk(3);
    chk(word === 0, "R8 word cleared", int'(word), 0);
    clr_n = 1'b1; cs_n = 1'b1; wait_clk(8);

    frame(16'hC0DE, 20);
    chk(word === 16'h0000, "R4 long frame", int'(word), 0);
    frame(16'h5AA5, 16);
    frame(16'h0000, 16);
    chk(word === 16'h0000, "R5 frame", int'(word), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog got %0d exp below %0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule